// File: doc/BRIEF.md
# Prioritized Serial-Port Interrupt Identification

This block merges the four interrupt causes of an asynchronous serial port into a single interrupt line. The four causes are receive data ready, transmit holding register empty, receive line error and modem signal change. Each cause has its own pending latch. The latch is set by a rising edge on that cause's raw condition flag. It stays set until the access that services the cause clears it. A four-bit enable register masks each cause.

When any enabled cause is pending, the interrupt output is high. An eight-bit identification byte then reports the single highest-priority enabled cause as a two-bit code, together with an active-low "pending" flag. The surrounding port logic wires in the raw flags and the read and write strobes of its own registers. The underlying status registers themselves are outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable register bit 0 masks receive-data-ready, bit 1 masks transmit-empty, bit 2 masks line-error and bit 3 masks modem-change. A pending cause whose enable bit is 0 neither raises `irq_o` nor appears in `iir_o`.
- R2: `ier_o` returns the written enable bits in positions 3:0. Positions 7:4 always read 0, whatever value is written.
- R3: `iir_o[0]` is 0 while at least one enabled cause is pending, and 1 otherwise. After reset, `iir_o` is 0x01, `irq_o` is 0 and `ier_o` is 0x00.
- R4: `iir_o[2:1]` holds the code of the highest-priority enabled pending cause. The order from highest to lowest is: line-error = 2'b11, receive-data-ready = 2'b10, transmit-empty = 2'b01, modem-change = 2'b00. With nothing pending the code is 2'b00.
- R5: `iir_o[7:3]` always reads 0.
- R6: A rising edge of a raw condition flag sets that cause's pending latch at the next clock edge. The latch stays set after the flag falls. A flag that stays high does not set the latch again after it has been cleared.
- R7: Reading the line-status register clears line-error. Reading the receive buffer clears receive-data-ready. Reading the modem-status register clears modem-change. Each of these strobes leaves the other causes unchanged.
- R8: Transmit-empty clears on a write to the transmit holding register. It also clears on an `iir_rd_i` read, but only when that read reports code 2'b01 with the pending flag low. A read that reports another cause leaves it pending.
- R9: `irq_o` is high exactly when some enabled cause is pending.
- R10: When a rising edge and the clearing strobe of the same cause occur in the same cycle, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_ready_i | input | 1 | Raw receive-data-ready flag |
| tx_empty_i | input | 1 | Raw transmit-holding-empty flag |
| line_err_i | input | 1 | Raw receive line error flag |
| modem_chg_i | input | 1 | Raw modem signal change flag |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| lsr_rd_i | input | 1 | Line-status register read strobe |
| msr_rd_i | input | 1 | Modem-status register read strobe |
| irq_o | output | 1 | Interrupt request |
| iir_o | output | 8 | Identification byte |
| ier_o | output | 8 | Enable register readback |

## Verification
The assertions assume that the raw flags and strobes are synchronous to `clk` and are stable across each rising edge. They also assume that `iir_rd_i` stands for the same read whose value the host latches from `iir_o` in that cycle. The stimulus changes every input on the falling edge only, and holds each strobe for exactly one cycle. It raises each raw flag for a single cycle, so every latch sees a clean edge. Between table vectors, every cause is cleared through its servicing strobe, so each vector starts with nothing pending.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int unsigned NSRC = 4;
   // source index = enable bit position
   localparam int unsigned SRC_RX    = 0;
   localparam int unsigned SRC_TX    = 1;
   localparam int unsigned SRC_LINE  = 2;
   localparam int unsigned SRC_MODEM = 3;

   typedef enum logic [1:0] {
      CODE_MODEM = 2'b00,
      CODE_TX    = 2'b01,
      CODE_RX    = 2'b10,
      CODE_LINE  = 2'b11
   } irq_code_t;
endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src #(
   parameter bit EDGE_SET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic clr_i,
   output logic pend_o
);
   logic raw_q;
   logic set_w;
   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= 1'b0;
      else        raw_q <= raw_i;
   end

   generate
      if (EDGE_SET) begin : g_edge
         assign set_w = raw_i & ~raw_q;
      end else begin : g_level
         assign set_w = raw_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     pend_q <= 1'b0;
      else if (set_w) pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
   end

   assign pend_o = pend_q;

   // R6: an edge on the raw flag is latched by the next edge
   a_r6_latch_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_i) |=> pend_o);
   // R7 / R8: a clear with no competing set empties the latch
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !raw_i) |=> !pend_o);
   // R10: set wins over clear in the same cycle
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && raw_i && !raw_q) |=> pend_o);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req_i,
   output irq_code_t       code_o,
   output logic            any_o
);
   always_comb begin
      if      (req_i[SRC_LINE]) code_o = CODE_LINE;
      else if (req_i[SRC_RX])   code_o = CODE_RX;
      else if (req_i[SRC_TX])   code_o = CODE_TX;
      else                      code_o = CODE_MODEM;
   end

   assign any_o = |req_i;

   // R4: the top-ranked request always wins
   a_r4_line_top: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[SRC_LINE] |-> (code_o == CODE_LINE));
   // R4: a reported code matches an active request
   a_r4_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (any_o && code_o == CODE_TX) |-> (req_i[SRC_TX] && !req_i[SRC_RX]));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned EN_W     = 4,
   parameter bit          EDGE_SET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_ready_i,
   input  logic             tx_empty_i,
   input  logic             line_err_i,
   input  logic             modem_chg_i,
   input  logic             ier_wr_i,
   input  logic [REG_W-1:0] ier_wdata_i,
   input  logic             rbr_rd_i,
   input  logic             thr_wr_i,
   input  logic             iir_rd_i,
   input  logic             lsr_rd_i,
   input  logic             msr_rd_i,
   output logic             irq_o,
   output logic [REG_W-1:0] iir_o,
   output logic [REG_W-1:0] ier_o
);
   localparam int unsigned CODE_LSB = 1;
   localparam int unsigned PAD_W    = REG_W - 3;
   localparam int unsigned EN_PAD_W = REG_W - EN_W;

   generate
      if (REG_W < 4) begin : g_bad_width
         $error("REG_W must be at least 4");
      end
      if (EN_W != NSRC) begin : g_bad_en
         $error("EN_W must equal the number of interrupt sources");
      end
   endgenerate

   logic [EN_W-1:0] ier_q;
   logic [NSRC-1:0] raw_w;
   logic [NSRC-1:0] clr_w;
   logic [NSRC-1:0] pend_w;
   logic [NSRC-1:0] req_w;
   irq_code_t       code_w;
   logic            any_w;
   logic            tx_reported_w;
   logic            unused_ier_hi;

   assign unused_ier_hi = ^ier_wdata_i[REG_W-1:EN_W];

   always_ff @(posedge clk) begin
      if (!rst_n)        ier_q <= '0;
      else if (ier_wr_i) ier_q <= ier_wdata_i[EN_W-1:0];
   end

   assign raw_w[SRC_RX]    = rx_ready_i;
   assign raw_w[SRC_TX]    = tx_empty_i;
   assign raw_w[SRC_LINE]  = line_err_i;
   assign raw_w[SRC_MODEM] = modem_chg_i;

   assign tx_reported_w    = iir_rd_i & any_w & (code_w == CODE_TX);

   assign clr_w[SRC_RX]    = rbr_rd_i;
   assign clr_w[SRC_TX]    = thr_wr_i | tx_reported_w;
   assign clr_w[SRC_LINE]  = lsr_rd_i;
   assign clr_w[SRC_MODEM] = msr_rd_i;

   genvar gi;
   generate
      for (gi = 0; gi < NSRC; gi++) begin : g_src
         uart_irq_src #(.EDGE_SET(EDGE_SET)) u_src (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_w[gi]),
            .clr_i  (clr_w[gi]),
            .pend_o (pend_w[gi])
         );
      end
   endgenerate

   assign req_w = pend_w & ier_q;

   uart_irq_prio u_prio (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_w),
      .code_o (code_w),
      .any_o  (any_w)
   );

   assign irq_o = |req_w;
   assign iir_o = {{PAD_W{1'b0}}, code_w, ~any_w};
   assign ier_o = {{EN_PAD_W{1'b0}}, ier_q};

   // R3: the pending flag is the inverse of the interrupt line
   a_r3_flag_vs_irq: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == !iir_o[0]);
   // R1: a masked cause alone never raises the line
   a_r1_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_o[EN_W-1:0] == '0) |-> !irq_o);
   // R8: a read that reports transmit-empty retires it
   a_r8_tx_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd_i && !iir_o[0] && iir_o[CODE_LSB +: 2] == CODE_TX && !tx_empty_i)
      |=> !pend_w[SRC_TX]);
   // R8: a read reporting another cause keeps transmit-empty
   a_r8_tx_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd_i && iir_o[CODE_LSB +: 2] != CODE_TX && !thr_wr_i && pend_w[SRC_TX])
      |=> pend_w[SRC_TX]);
endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_ready_i = 0, tx_empty_i = 0, line_err_i = 0, modem_chg_i = 0;
   logic       ier_wr_i = 0;
   logic [7:0] ier_wdata_i = 0;
   logic       rbr_rd_i = 0, thr_wr_i = 0, iir_rd_i = 0, lsr_rd_i = 0, msr_rd_i = 0;
   logic       irq_o;
   logic [7:0] iir_o, ier_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   uart_irq_ident dut (
      .clk(clk), .rst_n(rst_n),
      .rx_ready_i(rx_ready_i), .tx_empty_i(tx_empty_i),
      .line_err_i(line_err_i), .modem_chg_i(modem_chg_i),
      .ier_wr_i(ier_wr_i), .ier_wdata_i(ier_wdata_i),
      .rbr_rd_i(rbr_rd_i), .thr_wr_i(thr_wr_i), .iir_rd_i(iir_rd_i),
      .lsr_rd_i(lsr_rd_i), .msr_rd_i(msr_rd_i),
      .irq_o(irq_o), .iir_o(iir_o), .ier_o(ier_o)
   );

   // {enable[3:0], raise mask[3:0] (0 rx,1 tx,2 line,3 modem), expected iir}
   localparam int NV = 13;
   localparam logic [15:0] VEC [NV] = '{
      {4'hF, 4'h1, 8'h04}, {4'hF, 4'h2, 8'h02}, {4'hF, 4'h4, 8'h06},
      {4'hF, 4'h8, 8'h00}, {4'hF, 4'hF, 8'h06}, {4'hF, 4'hB, 8'h04},
      {4'hF, 4'hA, 8'h02}, {4'h0, 4'hF, 8'h01}, {4'hE, 4'h1, 8'h01},
      {4'hB, 4'hF, 8'h04}, {4'h8, 4'hF, 8'h00}, {4'h4, 4'h3, 8'h01},
      {4'h6, 4'hB, 8'h02}
   };

   task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic chk_iir(input string req, input logic [7:0] exp);
      chk8(req, iir_o, exp);
      chk8(req, {7'b0, irq_o}, {7'b0, ~exp[0]});
   endtask

   task automatic tick;
      @(negedge clk);
   endtask

   task automatic set_ier(input logic [7:0] v);
      ier_wdata_i = v; ier_wr_i = 1; tick; ier_wr_i = 0;
   endtask

   task automatic raise(input logic [3:0] m);
      rx_ready_i = m[0]; tx_empty_i = m[1]; line_err_i = m[2]; modem_chg_i = m[3];
      tick;
      rx_ready_i = 0; tx_empty_i = 0; line_err_i = 0; modem_chg_i = 0;
   endtask

   task automatic clear_all;
      rbr_rd_i = 1; lsr_rd_i = 1; msr_rd_i = 1; thr_wr_i = 1;
      tick;
      rbr_rd_i = 0; lsr_rd_i = 0; msr_rd_i = 0; thr_wr_i = 0;
   endtask

   initial begin
      repeat (3) tick;
      // R3 reset state
      chk_iir("R3 reset", 8'h01);
      chk8("R3 reset ier", ier_o, 8'h00);
      rst_n = 1; tick;

      // R2 upper enable bits
      set_ier(8'hFF);
      chk8("R2 ier upper zero", ier_o, 8'h0F);

      // R1 R4 R5 R9 table walk
      for (int i = 0; i < NV; i++) begin
         set_ier({4'h0, VEC[i][15:12]});
         raise(VEC[i][11:8]);
         chk_iir($sformatf("R4 R1 R9 R5 vec%0d", i), VEC[i][7:0]);
         clear_all;
         chk_iir($sformatf("R7 cleared vec%0d", i), 8'h01);
      end

      set_ier(8'h0F);
      // R6 persistence and no retrigger on held level
      line_err_i = 1; tick; tick;
      chk_iir("R6 latched", 8'h06);
      lsr_rd_i = 1; tick; lsr_rd_i = 0;
      chk_iir("R6 held level no reset", 8'h01);
      line_err_i = 0; tick;

      // R7 independent clears
      raise(4'h5);
      chk_iir("R7 line+rx", 8'h06);
      lsr_rd_i = 1; tick; lsr_rd_i = 0;
      chk_iir("R7 after lsr read", 8'h04);
      msr_rd_i = 1; tick; msr_rd_i = 0;
      chk_iir("R7 msr read no effect on rx", 8'h04);
      rbr_rd_i = 1; tick; rbr_rd_i = 0;
      chk_iir("R7 after rbr read", 8'h01);

      // R8 identification read rules
      raise(4'h3);
      iir_rd_i = 1; tick; iir_rd_i = 0;
      chk_iir("R8 read reporting rx keeps tx", 8'h04);
      rbr_rd_i = 1; tick; rbr_rd_i = 0;
      chk_iir("R8 tx now reported", 8'h02);
      iir_rd_i = 1; tick; iir_rd_i = 0;
      chk_iir("R8 read reporting tx clears it", 8'h01);
      raise(4'h2);
      thr_wr_i = 1; tick; thr_wr_i = 0;
      chk_iir("R8 holding write clears tx", 8'h01);
      // R8 masked tx not cleared by identification read
      raise(4'h2);
      set_ier(8'h0D);
      iir_rd_i = 1; tick; iir_rd_i = 0;
      set_ier(8'h0F);
      chk_iir("R8 unreported tx survives read", 8'h02);
      clear_all;

      // R10 set wins over clear
      modem_chg_i = 1; msr_rd_i = 1; tick;
      modem_chg_i = 0; msr_rd_i = 0;
      chk_iir("R10 set beats clear", 8'h00);
      clear_all;

      // R1 enable removed while pending, then restored
      raise(4'h8);
      set_ier(8'h07);
      chk_iir("R1 modem masked", 8'h01);
      set_ier(8'h08);
      chk_iir("R1 modem unmasked", 8'h00);

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule